// File: doc/BRIEF.md
# Multiplexed LCD Row/Column Scan Sequencer

This block produces the 1:40 multiplex scan of a 40-row by 101-column dot-matrix panel from a single oscillator clock. The frame has forty row periods and then an idle gap in which no row is driven. Before each row period starts, the block reads the display-memory bank that holds that row. From the bank it takes one bit for each column and applies the selected display mode. When the row period begins, it presents the result together with a one-hot row select.

A frame polarity flag flips once per frame so that the drivers can alternate drive polarity and keep DC off the panel. A power-down request switches every select off and raises a forcing flag that the output stage uses to park all drivers at the positive supply level. Reset is synchronous: the reset input must be seen high at two consecutive clock edges, and the block then comes out of reset in power-down.

The outputs are symbolic level selects only. Generating the analog bias levels is the job of the surrounding circuitry.

Top module: `lcd_scan_seq`

## Requirements
- R1: Rows are selected one at a time, as a one-hot `row_sel` that steps from bit 0 up to bit 39. Each row stays selected for 76 clocks.
- R2: After the row for bit 39, an idle gap of 32 clocks follows with `row_sel` and `col_on` all zero. Successive starts of the bit-0 row are therefore exactly 3072 clocks apart.
- R3: `frame_pol` inverts on the clock edge that selects the bit-0 row, and at no other time.
- R4: For row r, column c shows bit (r mod 8) of byte c of bank r/8. Byte c occupies `rd_data[8c+7:8c]`. The bank is requested with `rd_en` high and `rd_bank` = r/8 two clocks before the row begins. The data is taken one clock after the request.
- R5: `disp_mode` is sampled at each row boundary. 2'b00 shows blank (all columns 0). 2'b01 shows the memory bits. 2'b10 turns all columns on. 2'b11 shows the inverted memory bits.
- R6: `pd_req` is sampled at row and idle boundaries. When it is sampled high, `pd_force` becomes 1 and `row_sel` and `col_on` become zero at that boundary, and they stay so while the request persists.
- R7: After `pd_req` falls, the scan resumes within 32 clocks, and it always starts at the bit-0 row.
- R8: Reset happens only when `rst` is high at two consecutive rising edges. It leaves `pd_force` = 1, `frame_pol` = 0 and all selects zero. A one-clock `rst` pulse changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset request; acts when high for two edges |
| pd_req | input | 1 | Power-down request |
| disp_mode | input | 2 | Display mode: bit 1 all-on/invert select, bit 0 data select |
| rd_en | output | 1 | Display memory bank read strobe |
| rd_bank | output | 3 | Bank index to read (row / 8) |
| rd_data | input | 808 | Bank contents, byte c in bits 8c+7..8c, one clock after the strobe |
| row_sel | output | 40 | One-hot selected row |
| col_on | output | 101 | Column on/off level select for the current row |
| frame_pol | output | 1 | Frame drive polarity |
| pd_force | output | 1 | All drivers forced to the positive supply level |

## Verification
The assertions assume that `rst` is applied for at least two clocks before any check matters. They also assume that the memory answers every strobe with the addressed bank exactly one clock later. The bench models that memory as a fixed computed pattern with that latency, so the bank data never changes while a fetch is in flight. `pd_req` and `disp_mode` are driven only on falling edges, so each boundary samples them cleanly. Mode changes and power-down requests are placed at arbitrary points inside row periods, to show that they act only at boundaries.

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq #(
  parameter int ROWS      = 40,
  parameter int COLS      = 101,
  parameter int ROW_CLKS  = 76,
  parameter int IDLE_CLKS = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pd_req,
  input  logic [1:0]                    disp_mode,
  output logic                          rd_en,
  output logic [$clog2((ROWS+7)/8)-1:0] rd_bank,
  input  logic [COLS*8-1:0]             rd_data,
  output logic [ROWS-1:0]               row_sel,
  output logic [COLS-1:0]               col_on,
  output logic                          frame_pol,
  output logic                          pd_force
);
  localparam int RW = $clog2(ROWS + 1);
  localparam int CW = $clog2(ROW_CLKS > IDLE_CLKS ? ROW_CLKS : IDLE_CLKS);
  localparam int BW = $clog2((ROWS + 7) / 8);

  logic          rst_seen, rst_now, at_end;
  logic [RW-1:0] row, nxt;
  logic [CW-1:0] cyc, last;
  logic [2:0]    sub;
  logic [COLS-1:0] raw, shaded;

  assign rst_now = rst && rst_seen;
  assign last    = (row == RW'(ROWS)) ? CW'(IDLE_CLKS - 1) : CW'(ROW_CLKS - 1);
  assign at_end  = (cyc == last);
  assign nxt     = (row == RW'(ROWS)) ? '0 : row + 1'b1;
  assign rd_en   = (cyc == last - 1'b1) && (nxt != RW'(ROWS));
  assign rd_bank = BW'(nxt >> 3);
  assign sub     = nxt[2:0];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign raw[c] = rd_data[c*8 +: 8][sub];
  end

  assign shaded = {COLS{disp_mode[1] & ~disp_mode[0]}}
                | ({COLS{disp_mode[0]}} & (raw ^ {COLS{disp_mode[1]}}));

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_now) begin
      row       <= RW'(ROWS);
      cyc       <= '0;
      pd_force  <= 1'b1;
      frame_pol <= 1'b0;
      row_sel   <= '0;
      col_on    <= '0;
    end else if (at_end) begin
      cyc <= '0;
      if (pd_req) begin
        pd_force <= 1'b1;
        row      <= RW'(ROWS);
        row_sel  <= '0;
        col_on   <= '0;
      end else begin
        pd_force <= 1'b0;
        row      <= nxt;
        if (nxt == RW'(ROWS)) begin
          row_sel <= '0;
          col_on  <= '0;
        end else begin
          row_sel <= ROWS'(1) << nxt;
          col_on  <= shaded;
          if (nxt == '0) frame_pol <= ~frame_pol;
        end
      end
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst) $onehot0(row_sel));

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (row_sel != '0 && $past(row_sel) != '0 && row_sel != $past(row_sel))
      |-> row_sel == ($past(row_sel) << 1));

  p_pol_flip_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(row_sel[0]) |-> frame_pol != $past(frame_pol));

  p_pd_dark_r6: assert property (@(posedge clk) disable iff (rst)
    pd_force |-> (row_sel == '0 && col_on == '0));

  p_reset_pd_r8: assert property (@(posedge clk)
    (rst && rst_seen) |=> (pd_force && row_sel == '0 && !frame_pol));
endmodule

// File: tb/test_lcd_scan_seq.sv
module test_lcd_scan_seq;
  logic clk = 0, rst = 1, pd_req = 0;
  logic [1:0] disp_mode = 2'b01;
  logic rd_en;
  logic [2:0] rd_bank;
  logic [807:0] rd_data = '0;
  logic [39:0] row_sel;
  logic [100:0] col_on;
  logic frame_pol, pd_force;
  int checks = 0, fails = 0;
  bit go = 0, done = 0;

  always #5 clk = ~clk;

  lcd_scan_seq i_lcd_scan_seq (.clk, .rst, .pd_req, .disp_mode, .rd_en, .rd_bank,
    .rd_data, .row_sel, .col_on, .frame_pol, .pd_force);

  function automatic logic [7:0] memb(int b, int c);
    return 8'((b * 53 + c * 29 + 7) ^ (c << 2));
  endfunction

  always @(posedge clk)
    if (rd_en)
      for (int c = 0; c < 101; c++) rd_data[c*8 +: 8] <= memb(int'(rd_bank), c);

  // behavioural reference model
  int m_row = 40, m_cyc = 0;
  bit m_pd = 1, m_pol = 0, rst_prev = 0, e_rd = 0;
  logic [39:0]  e_sel = '0;
  logic [100:0] e_col = '0;

  always @(posedge clk) begin
    int last, nxt;
    if (rst && rst_prev) begin
      m_row = 40; m_cyc = 0; m_pd = 1; m_pol = 0; e_sel = '0; e_col = '0;
    end else begin
      last = (m_row == 40) ? 31 : 75;
      if (m_cyc == last) begin
        m_cyc = 0;
        if (pd_req) begin
          m_pd = 1; m_row = 40; e_sel = '0; e_col = '0;
        end else begin
          m_pd = 0;
          nxt = (m_row == 40) ? 0 : m_row + 1;
          m_row = nxt;
          if (nxt == 40) begin
            e_sel = '0; e_col = '0;
          end else begin
            if (nxt == 0) m_pol = ~m_pol;
            e_sel = 40'(1) << nxt;
            for (int c = 0; c < 101; c++) begin
              logic b;
              b = memb(nxt / 8, c)[nxt % 8];
              case (disp_mode)
                2'b00: e_col[c] = 1'b0;
                2'b01: e_col[c] = b;
                2'b10: e_col[c] = 1'b1;
                default: e_col[c] = ~b;
              endcase
            end
          end
        end
      end else m_cyc++;
    end
    rst_prev = rst;
    last = (m_row == 40) ? 31 : 75;
    nxt  = (m_row == 40) ? 0 : m_row + 1;
    e_rd = (m_cyc == last - 1) && (nxt != 40);
  end

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (go && !done) begin
    chk(row_sel == e_sel, "R1", 128'(row_sel), 128'(e_sel));
    chk(col_on == e_col, "R4,R5", 128'(col_on), 128'(e_col));
    chk(frame_pol == m_pol, "R3", 128'(frame_pol), 128'(m_pol));
    chk(pd_force == m_pd, "R6", 128'(pd_force), 128'(m_pd));
    chk(rd_en == e_rd, "R4 rd_en", 128'(rd_en), 128'(e_rd));
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0; go = 1;
    chk(pd_force && row_sel == 0 && col_on == 0 && !frame_pol, "R8 reset state",
        128'({pd_force, frame_pol}), 128'(2'b10));
    pd_req = 1; repeat (100) @(negedge clk);
    chk(pd_force == 1, "R6 held", 128'(pd_force), 128'(1));
    pd_req = 0; n = 0;
    while (!row_sel[0] && n < 100) begin @(negedge clk); n++; end
    chk(n <= 32 && row_sel[0], "R7 restart", 128'(n), 128'(32));
    n = 0;
    while (row_sel[0]) @(negedge clk);
    while (!row_sel[0] && n < 5000) begin @(negedge clk); n++; end
    n += 76;
    chk(n == 3072, "R2 frame length", 128'(n), 128'(3072));
    repeat (1000) @(negedge clk); disp_mode = 2'b11;
    repeat (3072) @(negedge clk); disp_mode = 2'b10;
    repeat (3072) @(negedge clk); disp_mode = 2'b00;
    repeat (3072) @(negedge clk); disp_mode = 2'b01;
    repeat (1037) @(negedge clk);
    pd_req = 1; repeat (200) @(negedge clk);
    chk(pd_force == 1 && row_sel == 0, "R6 mid frame", 128'(pd_force), 128'(1));
    pd_req = 0; repeat (4000) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    repeat (5) @(negedge clk);
    chk(pd_force == 0, "R8 short pulse", 128'(pd_force), 128'(0));
    repeat (500) @(negedge clk);
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    chk(pd_force == 1 && row_sel == 0 && !frame_pol, "R8 full reset",
        128'(pd_force), 128'(1));
    repeat (300) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule